// File: doc/BRIEF.md
# Bus Cycle Stretching Bridge

This block connects a fast accelerator processor to an older 16-bit host bus. The accelerator can finish a bus cycle in three clocks. The host bus needs four. The bridge watches the accelerator's address strobe, data strobe, transfer size and low address bits. Once the bridge has held the request for one deliberate extra clock, it drives the host address strobe and the upper and lower byte strobes. It also carries the read/write direction across.

The host acknowledge arrives without regard to the clock, so it passes through a two-flop synchronizer. Once the synchronized acknowledge is seen, the bridge returns a port acknowledge to the accelerator. That acknowledge always reports a 16-bit port. A long-word or three-byte request is therefore split by the accelerator into successive word cycles. Because the bridge frees every host strobe as soon as the accelerator drops its address strobe, each host cycle of such a split is cleanly separated from the next. A synchronous active-low reset puts every strobe back to its idle level.

Top module: `bus_stretch_bridge`

## Requirements
- R1: While `rst_n` is low, on the next clock edge `host_as_n`, `host_uds_n`, `host_lds_n` and `host_rw` go high and `acc_dsack_n` goes to 2'b11. This holds even when reset arrives in the middle of a cycle.
- R2: A host cycle starts only at a clock edge where `acc_as_n` and `acc_ds_n` are both sampled low. `host_as_n` stays high after that edge and goes low after the next one, so one clock of latency is inserted. An address strobe with the data strobe still high starts nothing.
- R3: `host_uds_n` is driven low during a host cycle exactly when the latched `acc_addr_lo[0]` is 0.
- R4: `host_lds_n` is driven low during a host cycle when the latched `acc_addr_lo[0]` is 1. It is also driven low when `acc_addr_lo[0]` is 0 and `acc_siz` is anything other than byte. Size codes are: 2'b01 byte, 2'b10 word, 2'b11 three-byte, 2'b00 long.
- R5: `host_rw` carries the `acc_rw` value latched when the cycle starts (1 = read) and stays stable for the whole host cycle. It is high when the bus is idle.
- R6: `host_dtack_n` passes through two synchronizer flops. `acc_dsack_n` is asserted after the third rising edge that samples `host_dtack_n` low, and not before.
- R7: An asserted acknowledge is always 2'b01 on `acc_dsack_n`, with bit 1 low and bit 0 high, meaning a 16-bit port. The values 2'b00 and 2'b10 never appear.
- R8: A clock edge that samples `acc_as_n` high ends any cycle in progress, including one still waiting for the host acknowledge. After that edge all host strobes are high and `acc_dsack_n` is 2'b11.
- R9: Two consecutive accelerator cycles, such as the halves of a long-word request, each produce their own host cycle. `host_as_n` is high for at least one clock between them.
- R10: `acc_dsack_n[1]` is low only while `host_as_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_as_n | input | 1 | Accelerator address strobe, active low |
| acc_ds_n | input | 1 | Accelerator data strobe, active low |
| acc_rw | input | 1 | Accelerator direction, 1 = read |
| acc_siz | input | 2 | Transfer size code |
| acc_addr_lo | input | 2 | Low two address bits |
| host_dtack_n | input | 1 | Host transfer acknowledge, asynchronous, active low |
| host_as_n | output | 1 | Host address strobe, active low |
| host_uds_n | output | 1 | Host upper byte strobe, active low |
| host_lds_n | output | 1 | Host lower byte strobe, active low |
| host_rw | output | 1 | Host direction, 1 = read |
| acc_dsack_n | output | 2 | Port acknowledge to the accelerator, active low |

## Verification
The cycle is exercised with byte requests at even and at odd addresses, which separate the upper-lane decode from the lower-lane decode. Word, three-byte and long requests at an even address confirm that both lanes fire. A word request at an odd address confirms that size alone does not enable the upper lane. Reads and writes are alternated so that a fixed direction cannot pass. Further patterns check other behaviours:
- A late data strobe tests the start condition.
- A back-to-back pair of halves tests release between cycles.
- An abandoned cycle tests release without an acknowledge.
- A reset in mid-cycle tests the return to idle.

The acknowledge is sampled on each clock after the host answers, which pins down the synchronizer depth exactly.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAG  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } bsb_state_e;

  localparam logic [1:0] SZ_LONG   = 2'b00;
  localparam logic [1:0] SZ_BYTE   = 2'b01;
  localparam logic [1:0] SZ_WORD   = 2'b10;
  localparam logic [1:0] SZ_TRIPLE = 2'b11;

  localparam logic [1:0] ACK_IDLE_N   = 2'b11;
  localparam logic [1:0] ACK_PORT16_N = 2'b01;

  typedef struct packed {
    logic upper;
    logic lower;
  } lane_t;

  // Byte lanes of a 16-bit port touched by an access, active high.
  function automatic lane_t lane_select(input logic [1:0] siz, input logic a0);
    lane_t l;
    l.upper = (a0 == 1'b0);
    l.lower = (a0 == 1'b1) || (siz != SZ_BYTE);
    return l;
  endfunction

endpackage

// File: rtl/bsb_sync.sv
module bsb_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{IDLE_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bsb_lane_dec.sv
module bsb_lane_dec
  import bsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [1:0] siz,
  input  logic [1:0] addr_lo,
  input  logic       rw,
  output lane_t      lane_q,
  output logic       rw_q
);
  lane_t lane_d;

  always_comb lane_d = lane_select(siz, addr_lo[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_q <= '0;
      rw_q   <= 1'b1;
    end else if (capture) begin
      lane_q <= lane_d;
      rw_q   <= rw;
    end
  end

  AST_LANE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_q.upper || lane_q.lower || $past(!rst_n) || !$past(capture) && !(lane_q.upper || lane_q.lower))); // R4
endmodule

// File: rtl/bsb_seq.sv
module bsb_seq
  import bsb_pkg::*;
#(
  parameter int LAG_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       acc_released,
  input  logic       dtack_seen,
  output logic       capture,
  output logic       host_active,
  output logic       ack_active
);
  localparam int LAG_W = (LAG_CLKS < 2) ? 1 : $clog2(LAG_CLKS + 1);
  localparam logic [LAG_W-1:0] LAG_LAST = LAG_W'(LAG_CLKS - 1);

  bsb_state_e state_q, state_d;
  logic [LAG_W-1:0] lag_cnt_q, lag_cnt_d;

  always_comb begin
    state_d   = state_q;
    lag_cnt_d = lag_cnt_q;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d   = ST_LAG;
          lag_cnt_d = '0;
          capture   = 1'b1;
        end
      end
      ST_LAG: begin
        if (acc_released)              state_d = ST_IDLE;
        else if (lag_cnt_q == LAG_LAST) state_d = ST_WAIT;
        else                           lag_cnt_d = lag_cnt_q + 1'b1;
      end
      ST_WAIT: begin
        if (acc_released)    state_d = ST_IDLE;
        else if (dtack_seen) state_d = ST_ACK;
      end
      ST_ACK: begin
        if (acc_released) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lag_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      lag_cnt_q <= lag_cnt_d;
    end
  end

  assign host_active = (state_q == ST_WAIT) || (state_q == ST_ACK);
  assign ack_active  = (state_q == ST_ACK);

  AST_ACK_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_active) |-> $past(host_active)); // R6
  AST_NO_START_UNREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture) |-> start_req); // R2
endmodule

// File: rtl/bus_stretch_bridge.sv
module bus_stretch_bridge
  import bsb_pkg::*;
#(
  parameter int LAG_CLKS    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_as_n,
  input  logic       acc_ds_n,
  input  logic       acc_rw,
  input  logic [1:0] acc_siz,
  input  logic [1:0] acc_addr_lo,
  input  logic       host_dtack_n,
  output logic       host_as_n,
  output logic       host_uds_n,
  output logic       host_lds_n,
  output logic       host_rw,
  output logic [1:0] acc_dsack_n
);
  logic  dtack_sync_n;
  logic  start_req;
  logic  acc_released;
  logic  capture;
  logic  host_active;
  logic  ack_active;
  lane_t lane_q;
  logic  rw_q;

  assign start_req    = !acc_as_n && !acc_ds_n;
  assign acc_released = acc_as_n;

  bsb_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (host_dtack_n),
    .q_sync  (dtack_sync_n)
  );

  bsb_lane_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .siz     (acc_siz),
    .addr_lo (acc_addr_lo),
    .rw      (acc_rw),
    .lane_q  (lane_q),
    .rw_q    (rw_q)
  );

  bsb_seq #(.LAG_CLKS(LAG_CLKS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .acc_released (acc_released),
    .dtack_seen   (!dtack_sync_n),
    .capture      (capture),
    .host_active  (host_active),
    .ack_active   (ack_active)
  );

  assign host_as_n   = !host_active;
  assign host_uds_n  = !(host_active && lane_q.upper);
  assign host_lds_n  = !(host_active && lane_q.lower);
  assign host_rw     = host_active ? rw_q : 1'b1;
  assign acc_dsack_n = ack_active ? ACK_PORT16_N : ACK_IDLE_N;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (host_as_n && host_uds_n && host_lds_n && host_rw && acc_dsack_n == 2'b11)); // R1
  AST_ACK_PORT16: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_dsack_n == 2'b11) || (acc_dsack_n == 2'b01)); // R7
  AST_ACK_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_dsack_n[1] |-> !host_as_n); // R10
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_as_n |=> (host_as_n && host_uds_n && host_lds_n && acc_dsack_n == 2'b11)); // R8
  AST_RW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_as_n && $past(!host_as_n)) |-> $stable(host_rw)); // R5
  AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_uds_n || !host_lds_n) |-> !host_as_n); // R3

  generate
    if (LAG_CLKS == 1) begin : g_lag_chk
      AST_ONE_CLK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_as_n) && !$past(!rst_n, 1) && !$past(!rst_n, 2))
          |-> $past(!acc_as_n && !acc_ds_n, 2)); // R2
    end
    if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(acc_dsack_n[1]) && !$past(!rst_n, 1) && !$past(!rst_n, 2) && !$past(!rst_n, 3))
          |-> $past(!host_dtack_n, 3)); // R6
    end
  endgenerate
endmodule

// File: tb/bus_stretch_bridge_test.sv
module bus_stretch_bridge_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_as_n, acc_ds_n, acc_rw;
  logic [1:0] acc_siz, acc_addr_lo;
  logic       host_dtack_n;
  logic       host_as_n, host_uds_n, host_lds_n, host_rw;
  logic [1:0] acc_dsack_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_stretch_bridge uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_as_n     (acc_as_n),
    .acc_ds_n     (acc_ds_n),
    .acc_rw       (acc_rw),
    .acc_siz      (acc_siz),
    .acc_addr_lo  (acc_addr_lo),
    .host_dtack_n (host_dtack_n),
    .host_as_n    (host_as_n),
    .host_uds_n   (host_uds_n),
    .host_lds_n   (host_lds_n),
    .host_rw      (host_rw),
    .acc_dsack_n  (acc_dsack_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "host_as_n idle", int'(host_as_n), 1);
    chk(req, "host_uds_n idle", int'(host_uds_n), 1);
    chk(req, "host_lds_n idle", int'(host_lds_n), 1);
    chk(req, "host_rw idle", int'(host_rw), 1);
    chk(req, "acc_dsack_n idle", int'(acc_dsack_n), 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; acc_as_n = 1'b1; acc_ds_n = 1'b1; acc_rw = 1'b1;
    acc_siz = 2'b10; acc_addr_lo = 2'b00; host_dtack_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
  endtask

  // One full accelerator cycle. Enters and leaves on a falling edge with the strobes high.
  task automatic t_cycle(input logic rw, input logic [1:0] siz, input logic [1:0] a,
                         input logic exp_upper, input logic exp_lower);
    @(negedge clk);
    acc_as_n = 1'b0; acc_ds_n = 1'b0; acc_rw = rw; acc_siz = siz; acc_addr_lo = a;
    @(negedge clk);
    chk("R2", "host_as_n during lag", int'(host_as_n), 1);
    @(negedge clk);
    chk("R2", "host_as_n after lag", int'(host_as_n), 0);
    chk("R3", "host_uds_n", int'(host_uds_n), int'(!exp_upper));
    chk("R4", "host_lds_n", int'(host_lds_n), int'(!exp_lower));
    chk("R5", "host_rw", int'(host_rw), int'(rw));
    host_dtack_n = 1'b0;
    acc_rw = ~rw;
    @(negedge clk);
    chk("R6", "dsack after 1 edge", int'(acc_dsack_n), 3);
    chk("R5", "host_rw held", int'(host_rw), int'(rw));
    @(negedge clk);
    chk("R6", "dsack after 2 edges", int'(acc_dsack_n), 3);
    @(negedge clk);
    chk("R7", "dsack after 3 edges", int'(acc_dsack_n), 1);
    chk("R10", "host_as_n with ack", int'(host_as_n), 0);
    acc_as_n = 1'b1; acc_ds_n = 1'b1; host_dtack_n = 1'b1;
    @(negedge clk);
    chk_idle("R8");
  endtask

  task automatic t_late_ds();
    @(negedge clk);
    acc_as_n = 1'b0; acc_ds_n = 1'b1; acc_rw = 1'b0; acc_siz = 2'b01; acc_addr_lo = 2'b01;
    repeat (3) begin
      @(negedge clk);
      chk("R2", "no start without ds", int'(host_as_n), 1);
    end
    acc_ds_n = 1'b0;
    @(negedge clk);
    chk("R2", "lag after ds", int'(host_as_n), 1);
    @(negedge clk);
    chk("R2", "start after ds", int'(host_as_n), 0);
    chk("R4", "odd byte lower", int'(host_lds_n), 0);
    chk("R3", "odd byte upper", int'(host_uds_n), 1);
    acc_as_n = 1'b1; acc_ds_n = 1'b1;
    @(negedge clk);
    chk_idle("R8");
  endtask

  task automatic t_long_split();
    t_cycle(1'b1, 2'b00, 2'b00, 1'b1, 1'b1);
    chk("R9", "gap between halves", int'(host_as_n), 1);
    t_cycle(1'b1, 2'b10, 2'b10, 1'b1, 1'b1);
  endtask

  task automatic t_abort();
    @(negedge clk);
    acc_as_n = 1'b0; acc_ds_n = 1'b0; acc_rw = 1'b0; acc_siz = 2'b10; acc_addr_lo = 2'b00;
    repeat (2) @(negedge clk);
    chk("R8", "abort cycle started", int'(host_as_n), 0);
    acc_as_n = 1'b1; acc_ds_n = 1'b1;
    @(negedge clk);
    chk_idle("R8");
    host_dtack_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "no ack when idle", int'(acc_dsack_n), 3);
    host_dtack_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    acc_as_n = 1'b0; acc_ds_n = 1'b0; acc_rw = 1'b0; acc_siz = 2'b10; acc_addr_lo = 2'b00;
    repeat (2) @(negedge clk);
    host_dtack_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "ack before reset", int'(acc_dsack_n), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    acc_as_n = 1'b1; acc_ds_n = 1'b1; host_dtack_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_cycle(1'b1, 2'b01, 2'b00, 1'b1, 1'b0); // byte even
    t_cycle(1'b0, 2'b01, 2'b01, 1'b0, 1'b1); // byte odd
    t_cycle(1'b1, 2'b10, 2'b00, 1'b1, 1'b1); // word even
    t_cycle(1'b0, 2'b10, 2'b01, 1'b0, 1'b1); // word odd
    t_cycle(1'b0, 2'b11, 2'b10, 1'b1, 1'b1); // three-byte even
    t_late_ds();
    t_long_split();
    t_abort();
    t_mid_reset();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule